// File: doc/BRIEF.md
# Socket Status Change Interrupt Unit

This unit watches the status pins of one removable-card socket: two card-seat pins, a ready line, a two-bit battery or ring line, a general-purpose input, write-protect and a power-good flag. It shows their live values in a status register. It records transitions as sticky flags in a change register. When an enabled change flag is pending, it raises one line of a 16-line interrupt bus. It also routes the card's own interrupt request to a second 16-line bus. A programmable card-type bit decides whether flag 0 means "battery went dead" (memory card) or "ring detected" (I/O card).

Software reaches every register through an 8-bit two-address port. A write at address 0 selects a register index. A read or write at address 1 then accesses the selected register. Change flags are acknowledged in one of two ways, chosen by a global-control bit. In read-acknowledge mode, reading the change register clears it. In explicit mode, writing ones clears the matching flags. Seat and ready pins are debounced. All pins are synchronized before use.

Top module: `socket_csc_unit`

## Requirements
- R1: Index 0x01 reads live status: bit 7 general-purpose input, bit 6 power good, bit 5 debounced ready, bit 4 write-protect, bit 3 seat pin 1, bit 2 seat pin 0 (both debounced, so 11 means seated), bits 1:0 battery pins (11 good, 10 warning, 0x dead).
- R2: Change register at index 0x04. Bit 4 sets on any edge of the general-purpose input. Bit 3 sets on any debounced edge of either seat pin. Bit 2 sets on any debounced edge of ready. Bits 7:5 read 0. Power-good and write-protect edges set nothing.
- R3: A seat or ready pin change takes effect only after it has held for DEB_CYCLES consecutive cycles. A shorter pulse changes neither status nor change flags.
- R4: With a memory card (index 0x03 bit 5 = 0), bit 1 sets when the battery pins enter 10. Bit 0 sets when battery bit 1 falls (the battery goes dead).
- R5: With index 0x1E bit 2 = 0, reading index 0x04 returns the flags and clears them. Writes to index 0x04 have no effect.
- R6: With an I/O card (index 0x03 bit 5 = 1), bit 0 sets on a falling edge of battery pin 0 (ring). Bit 1 never sets.
- R7: stat_irq_o drives the single line numbered by index 0x05 bits 7:4 while (change[3:0] & index 0x05 bits 3:0) is nonzero. Bit 4 of the change register never raises it.
- R8: Only IRQ numbers 3, 4, 5, 7, 9, 10, 11, 12, 14 and 15 are driven (mask 0xDEB8). Any other number, including 0, drives no line.
- R9: With index 0x1E bit 2 = 1, reads of index 0x04 leave the flags intact. Writing a 1 to a flag bit clears that bit.
- R10: A change event wins over an acknowledge (read or write-one) that lands on the same clock edge. The flag ends up set.
- R11: card_irq_o drives the line numbered by index 0x03 bits 3:0 while the synchronized card request is high, bit 4 is 1 and bit 5 is 1. The mask of R8 applies.
- R12: card_rst_o is high while index 0x03 bit 6 is 0, which includes the reset state.
- R13: Address 0 reads back the index. Indexes 0x03 and 0x05 read back fully. Index 0x1E reads only bit 2. Unlisted indexes read 0, and a write to 0x01 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects index, 1 selects data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects at clock edge) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| cd_i | input | 2 | Seat pins, high when seated |
| rdy_i | input | 1 | Card ready |
| batt_i | input | 2 | Battery state, or ring on bit 0 for I/O cards |
| gpi_i | input | 1 | General-purpose input |
| wp_i | input | 1 | Write-protect |
| pwr_i | input | 1 | Power good |
| card_irq_i | input | 1 | Card interrupt request |
| stat_irq_o | output | 16 | Status-change interrupt lines |
| card_irq_o | output | 16 | Routed card interrupt lines |
| card_rst_o | output | 1 | Card reset, active high |

## Verification
Two functions can meet on one clock edge: a new change event setting a flag, and software acknowledging the change register. The bench toggles the general-purpose input one cycle before a register index write. With two synchronizer stages and one edge register, the flag sets on the same edge that the following data-port access acts on. In explicit mode that access is a write-one of the same bit. In read-acknowledge mode it is a read. The bench then reads the register back and expects the flag still set. It also expects the colliding read itself to have returned the old, clear value.

// File: rtl/socket_csc_pkg.sv
package socket_csc_pkg;
  localparam int DW        = 8;
  localparam int IRQ_NUM_W = 4;
  localparam int IRQ_LINES = 1 << IRQ_NUM_W;
  localparam int CHG_W     = 5;

  localparam logic [DW-1:0] IDX_STATUS = 8'h01;
  localparam logic [DW-1:0] IDX_INTCTL = 8'h03;
  localparam logic [DW-1:0] IDX_CHG    = 8'h04;
  localparam logic [DW-1:0] IDX_CHGCFG = 8'h05;
  localparam logic [DW-1:0] IDX_GCTL   = 8'h1E;

  localparam int GCTL_EXPACK_BIT = 2;
  localparam logic [IRQ_LINES-1:0] LEGAL_IRQ_MASK = 16'hDEB8;

  typedef enum logic {CARD_MEM = 1'b0, CARD_IO = 1'b1} card_kind_e;

  function automatic logic [IRQ_LINES-1:0] irq_line(input logic [IRQ_NUM_W-1:0] num,
                                                    input logic req);
    logic [IRQ_LINES-1:0] v;
    v = '0;
    if (req && LEGAL_IRQ_MASK[num]) v[num] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/socket_csc_sync.sv
module socket_csc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= in_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign out_o = stg_q[STAGES-1];
endmodule

// File: rtl/socket_csc_filt.sv
// Holds a settled copy of synchronized pins; nxt_o is the value taken at the next edge.
module socket_csc_filt #(
  parameter int W = 1,
  parameter int DEB_CYCLES = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] nxt_o
);
  if (DEB_CYCLES <= 1) begin : g_plain
    logic [W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= '0;
      else         val_q <= smp_i;
    end
    assign val_o = val_q;
    assign nxt_o = smp_i;
  end else begin : g_deb
    localparam int CW = $clog2(DEB_CYCLES);
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic          bit_q;
      logic [CW-1:0] cnt_q;
      logic          diff, hit;
      assign diff = smp_i[b] ^ bit_q;
      assign hit  = diff && (cnt_q == CW'(DEB_CYCLES - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bit_q <= 1'b0;
          cnt_q <= '0;
        end else if (!diff || hit) begin
          cnt_q <= '0;
          if (hit) bit_q <= smp_i[b];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign val_o[b] = bit_q;
      assign nxt_o[b] = hit ? smp_i[b] : bit_q;
    end
  end
endmodule

// File: rtl/socket_csc_chg.sv
module socket_csc_chg
  import socket_csc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  card_kind_e       kind_i,
  input  logic             gpi_val_i,
  input  logic             gpi_nxt_i,
  input  logic [1:0]       cd_val_i,
  input  logic [1:0]       cd_nxt_i,
  input  logic             rdy_val_i,
  input  logic             rdy_nxt_i,
  input  logic [1:0]       batt_val_i,
  input  logic [1:0]       batt_nxt_i,
  input  logic             clr_all_i,
  input  logic [CHG_W-1:0] clr_mask_i,
  output logic [CHG_W-1:0] chg_o
);
  logic [CHG_W-1:0] set, clr, chg_q;

  always_comb begin
    set    = '0;
    set[4] = gpi_val_i ^ gpi_nxt_i;
    set[3] = |(cd_val_i ^ cd_nxt_i);
    set[2] = rdy_val_i ^ rdy_nxt_i;
    if (kind_i == CARD_IO) begin
      set[0] = batt_val_i[0] && !batt_nxt_i[0];
    end else begin
      set[1] = (batt_nxt_i == 2'b10) && (batt_val_i != 2'b10);
      set[0] = batt_val_i[1] && !batt_nxt_i[1];
    end
    clr = clr_all_i ? '1 : clr_mask_i;
  end

  // events beat acknowledges on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= '0;
    else         chg_q <= (chg_q & ~clr) | set;
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/socket_csc_regs.sv
module socket_csc_regs
  import socket_csc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    status_i,
  input  logic [CHG_W-1:0] chg_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    intctl_o,
  output logic [DW-1:0]    chgcfg_o,
  output logic             clr_all_o,
  output logic [CHG_W-1:0] clr_mask_o
);
  logic [DW-1:0] idx_q, intctl_q, chgcfg_q;
  logic          expack_q;
  logic          data_wr, data_rd, at_chg;

  assign data_wr = wr_i && addr_i;
  assign data_rd = rd_i && addr_i;
  assign at_chg  = (idx_q == IDX_CHG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      intctl_q <= '0;
      chgcfg_q <= '0;
      expack_q <= 1'b0;
    end else begin
      if (wr_i && !addr_i) idx_q <= wdata_i;
      if (data_wr) begin
        case (idx_q)
          IDX_INTCTL: intctl_q <= wdata_i;
          IDX_CHGCFG: chgcfg_q <= wdata_i;
          IDX_GCTL:   expack_q <= wdata_i[GCTL_EXPACK_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o = idx_q;
    end else begin
      case (idx_q)
        IDX_STATUS: rdata_o = status_i;
        IDX_INTCTL: rdata_o = intctl_q;
        IDX_CHG:    rdata_o = {{(DW-CHG_W){1'b0}}, chg_i};
        IDX_CHGCFG: rdata_o = chgcfg_q;
        IDX_GCTL:   rdata_o[GCTL_EXPACK_BIT] = expack_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign clr_all_o  = data_rd && at_chg && !expack_q;
  assign clr_mask_o = (data_wr && at_chg && expack_q) ? wdata_i[CHG_W-1:0] : '0;
  assign intctl_o   = intctl_q;
  assign chgcfg_o   = chgcfg_q;
endmodule

// File: rtl/socket_csc_unit.sv
module socket_csc_unit
  import socket_csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [1:0]           cd_i,
  input  logic                 rdy_i,
  input  logic [1:0]           batt_i,
  input  logic                 gpi_i,
  input  logic                 wp_i,
  input  logic                 pwr_i,
  input  logic                 card_irq_i,
  output logic [IRQ_LINES-1:0] stat_irq_o,
  output logic [IRQ_LINES-1:0] card_irq_o,
  output logic                 card_rst_o
);
  logic [2:0] deb_smp, deb_val, deb_nxt;
  logic [2:0] edg_smp, edg_val, edg_nxt;
  logic [2:0] lvl_smp;
  logic [DW-1:0] status, intctl, chgcfg;
  logic [CHG_W-1:0] chg, clr_mask;
  logic clr_all;
  card_kind_e kind;

  // seat and ready: synchronized and debounced
  socket_csc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_deb (
    .clk_i, .rst_ni, .in_i({rdy_i, cd_i}), .out_o(deb_smp));
  socket_csc_filt #(.W(3), .DEB_CYCLES(DEB_CYCLES)) u_filt_deb (
    .clk_i, .rst_ni, .smp_i(deb_smp), .val_o(deb_val), .nxt_o(deb_nxt));

  // gpi and battery: synchronized, edge-tracked
  socket_csc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_edg (
    .clk_i, .rst_ni, .in_i({gpi_i, batt_i}), .out_o(edg_smp));
  socket_csc_filt #(.W(3), .DEB_CYCLES(1)) u_filt_edg (
    .clk_i, .rst_ni, .smp_i(edg_smp), .val_o(edg_val), .nxt_o(edg_nxt));

  // level-only pins
  socket_csc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_lvl (
    .clk_i, .rst_ni, .in_i({card_irq_i, pwr_i, wp_i}), .out_o(lvl_smp));

  assign status = {edg_val[2], lvl_smp[1], deb_val[2], lvl_smp[0],
                   deb_val[1], deb_val[0], edg_val[1:0]};
  assign kind   = card_kind_e'(intctl[5]);

  socket_csc_chg u_chg (
    .clk_i, .rst_ni,
    .kind_i     (kind),
    .gpi_val_i  (edg_val[2]),
    .gpi_nxt_i  (edg_nxt[2]),
    .cd_val_i   (deb_val[1:0]),
    .cd_nxt_i   (deb_nxt[1:0]),
    .rdy_val_i  (deb_val[2]),
    .rdy_nxt_i  (deb_nxt[2]),
    .batt_val_i (edg_val[1:0]),
    .batt_nxt_i (edg_nxt[1:0]),
    .clr_all_i  (clr_all),
    .clr_mask_i (clr_mask),
    .chg_o      (chg));

  socket_csc_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .status_i   (status),
    .chg_i      (chg),
    .rdata_o,
    .intctl_o   (intctl),
    .chgcfg_o   (chgcfg),
    .clr_all_o  (clr_all),
    .clr_mask_o (clr_mask));

  assign stat_irq_o = irq_line(chgcfg[7:4], |(chg[3:0] & chgcfg[3:0]));
  assign card_irq_o = irq_line(intctl[3:0], lvl_smp[2] && intctl[4] && (kind == CARD_IO));
  assign card_rst_o = !intctl[6];
endmodule

// File: rtl/socket_csc_unit_chk.sv
module socket_csc_unit_chk
  import socket_csc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 addr_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [DW-1:0]        wdata_i,
  input logic [DW-1:0]        rdata_o,
  input logic [IRQ_LINES-1:0] stat_irq_o,
  input logic [IRQ_LINES-1:0] card_irq_o,
  input logic                 card_rst_o
);
  logic [DW-1:0] idx_shadow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_shadow <= '0;
    else if (wr_i && !addr_i) idx_shadow <= wdata_i;
  end

  assert_stat_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_irq_o));

  assert_stat_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_irq_o & ~LEGAL_IRQ_MASK) == '0);

  assert_card_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(card_irq_o) && ((card_irq_o & ~LEGAL_IRQ_MASK) == '0));

  assert_card_rst_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && idx_shadow == IDX_INTCTL) |=> (card_rst_o == !$past(wdata_i[6])));

  assert_chg_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i && idx_shadow == IDX_CHG) |-> (rdata_o[7:5] == 3'b000));

  assert_gctl_bits_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i && idx_shadow == IDX_GCTL) |-> ((rdata_o & 8'hFB) == 8'h00));
endmodule

bind socket_csc_unit socket_csc_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .stat_irq_o(stat_irq_o),
  .card_irq_o(card_irq_o), .card_rst_o(card_rst_o));

// File: tb/socket_csc_unit_test.sv
module socket_csc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cd = '0;
  logic rdy = 1'b0, gpi = 1'b0, wp = 1'b0, pwr = 1'b0, cirq = 1'b0;
  logic [1:0] batt = '0;
  logic [15:0] stat_irq, card_irq;
  logic card_rst;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  socket_csc_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .cd_i(cd), .rdy_i(rdy), .batt_i(batt),
    .gpi_i(gpi), .wp_i(wp), .pwr_i(pwr), .card_irq_i(cirq),
    .stat_irq_o(stat_irq), .card_irq_o(card_irq), .card_rst_o(card_rst));

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (rd) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_op(input logic a, input logic w, input logic r, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wr = w; rd = r; wdata = d;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    bus_op(1'b0, 1'b1, 1'b0, idx);
    bus_op(1'b1, 1'b1, 1'b0, val);
    bus_op(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] e, input string t);
    bus_op(1'b0, 1'b1, 1'b0, idx);
    bus_op(1'b1, 1'b0, 1'b1, 8'h00);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_op(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] e, input string t);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %04h expected %04h", t, act, e);
    end
  endtask

  function automatic logic [7:0] stat_exp();
    return {gpi, pwr, rdy, wp, cd[1], cd[0], batt};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // reset state
    check({15'b0, card_rst}, 16'h0001, "R12 reset card_rst");
    check(stat_irq, 16'h0000, "R7 reset stat_irq");
    check(card_irq, 16'h0000, "R11 reset card_irq");
    rd_reg(8'h01, 8'h00, "R1 reset status");
    rd_reg(8'h04, 8'h00, "R2 reset change");
    rd_reg(8'h03, 8'h00, "R13 reset intctl");

    // live status and change edges
    gpi = 1; pwr = 1; rdy = 1; wp = 1; cd = 2'b11; batt = 2'b11;
    settle(14);
    rd_reg(8'h01, 8'hFF, "R1 status all set");
    rd_reg(8'h04, 8'h1C, "R2 change gpi/cd/rdy");
    rd_reg(8'h04, 8'h00, "R5 read cleared");

    // glitch shorter than debounce window
    rdy = 0; settle(2); rdy = 1;
    settle(14);
    rd_reg(8'h04, 8'h00, "R3 glitch no change");
    rd_reg(8'h01, stat_exp(), "R3 glitch status");

    // memory card battery transitions
    batt = 2'b10; settle(6);
    batt = 2'b00; settle(6);
    rd_reg(8'h01, stat_exp(), "R1 battery dead status");
    rd_reg(8'h04, 8'h03, "R4 warning and dead");
    batt = 2'b11; settle(6);
    rd_reg(8'h04, 8'h00, "R4 recovery sets nothing");

    // I/O card ring indicate
    wr_reg(8'h03, 8'h20);
    rd_reg(8'h03, 8'h20, "R13 intctl readback");
    batt = 2'b10; settle(6);
    batt = 2'b11; settle(6);
    rd_reg(8'h04, 8'h01, "R6 ring only bit0");
    wr_reg(8'h03, 8'h40);
    settle(1);
    check({15'b0, card_rst}, 16'h0000, "R12 reset released");

    // status change interrupt
    wr_reg(8'h05, 8'h38);
    cd[0] = 0; settle(14);
    check(stat_irq, 16'h0008, "R7 irq3 on cd change");
    rd_reg(8'h04, 8'h08, "R2 cd change bit");
    settle(1);
    check(stat_irq, 16'h0000, "R7 irq drops after ack");
    gpi = 0; settle(6);
    check(stat_irq, 16'h0000, "R7 gpi not an irq source");
    rd_reg(8'h04, 8'h10, "R2 gpi falling edge");
    wr_reg(8'h05, 8'h34);
    cd[0] = 1; settle(14);
    check(stat_irq, 16'h0000, "R7 source disabled");
    rd_reg(8'h04, 8'h08, "R2 cd rising edge");

    // IRQ legality
    wr_reg(8'h05, 8'h68);
    cd[0] = 0; settle(14);
    check(stat_irq, 16'h0000, "R8 irq6 illegal");
    rd_reg(8'h04, 8'h08, "R8 flag still latched");
    wr_reg(8'h05, 8'h08);
    cd[0] = 1; settle(14);
    check(stat_irq, 16'h0000, "R8 irq0 none");
    rd_reg(8'h04, 8'h08, "R8 flag with irq0");
    wr_reg(8'h05, 8'hF8);
    cd[0] = 0; settle(14);
    check(stat_irq, 16'h8000, "R8 irq15 legal");
    rd_reg(8'h04, 8'h08, "R5 ack irq15");

    // explicit acknowledge
    wr_reg(8'h1E, 8'hFF);
    rd_reg(8'h1E, 8'h04, "R13 gctl only bit2");
    cd[0] = 1; rdy = 0; settle(14);
    rd_reg(8'h04, 8'h0C, "R9 first read");
    rd_reg(8'h04, 8'h0C, "R9 read keeps flags");
    check(stat_irq, 16'h8000, "R9 irq held after read");
    wr_reg(8'h04, 8'h08);
    rd_reg(8'h04, 8'h04, "R9 w1c cd bit");
    settle(1);
    check(stat_irq, 16'h0000, "R9 irq after w1c");
    wr_reg(8'h04, 8'h04);
    rd_reg(8'h04, 8'h00, "R9 w1c ready bit");

    // collision: event and write-one on the same edge
    @(posedge clk); #1; gpi = 1;
    wr_reg(8'h04, 8'h10);
    settle(2);
    rd_reg(8'h04, 8'h10, "R10 set beats w1c");
    wr_reg(8'h04, 8'h10);
    rd_reg(8'h04, 8'h00, "R9 cleared after collision");

    // collision: event and clearing read on the same edge
    wr_reg(8'h1E, 8'h00);
    @(posedge clk); #1; gpi = 0;
    rd_reg(8'h04, 8'h00, "R10 colliding read old value");
    rd_reg(8'h04, 8'h10, "R10 set beats read clear");
    rd_reg(8'h04, 8'h00, "R5 cleared after collision");

    // writes to change register ignored in read-ack mode
    gpi = 1; settle(6);
    wr_reg(8'h04, 8'h10);
    rd_reg(8'h04, 8'h10, "R5 write ignored");

    // card interrupt routing
    cirq = 1;
    wr_reg(8'h03, 8'h3A);
    settle(5);
    check(card_irq, 16'h0400, "R11 routed irq10");
    check({15'b0, card_rst}, 16'h0001, "R12 bit6 low asserts reset");
    wr_reg(8'h03, 8'h1A);
    settle(1);
    check(card_irq, 16'h0000, "R11 memory card blocks");
    wr_reg(8'h03, 8'h2A);
    settle(1);
    check(card_irq, 16'h0000, "R11 enable off");
    wr_reg(8'h03, 8'h36);
    settle(1);
    check(card_irq, 16'h0000, "R11 irq6 illegal");
    wr_reg(8'h03, 8'h3A);
    cirq = 0; settle(5);
    check(card_irq, 16'h0000, "R11 request dropped");

    // register map
    rd_reg(8'h02, 8'h00, "R13 unlisted index");
    rd_reg(8'h55, 8'h00, "R13 unlisted index high");
    wr_reg(8'h01, 8'h00);
    rd_reg(8'h01, stat_exp(), "R13 status write ignored");
    rd_reg(8'h05, 8'hF8, "R13 chgcfg readback");
    bus_op(1'b0, 1'b1, 1'b0, 8'h05);
    bus_op(1'b0, 1'b0, 1'b1, 8'h00);
    exp_q.push_back(8'h05);
    tag_q.push_back("R13 index port readback");
    bus_op(1'b0, 1'b0, 1'b0, 8'h00);

    settle(3);
    if (exp_q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule